// File: doc/BRIEF.md
# Holdover Frequency Memory Controller

This block sits between the loop filter of a digital PLL and its controlled oscillator. It chooses the frequency control word that drives the oscillator in one of three operating modes. In tracking mode it passes the live loop-filter word through. In holdover it replays a remembered word. In freerun it drives a fixed nominal word, so the output is only as accurate as the master clock.

While tracking with lock asserted, the block counts a millisecond tick. After every `TICKS_PER_SAMPLE` ticks (30 by default) it stores the live word in one of two snapshot slots, using the slots in turn. When holdover begins, it latches the older snapshot, which is between one and two sample periods old. Disturbance that arrived just before the loss of reference therefore does not reach the holdover frequency. A fast-lock control is passed through, registered, as a wide-tracking hint for the loop while tracking.

The controller is a three-state machine driven by the mode input: TRACK (code 00), HOLD (code 01) and FREE (codes 10 and 11). Every state can go directly to every other state. Two transitions have side effects. The transition into HOLD from TRACK or FREE latches the holdover word. The transition HOLD to TRACK clears both snapshot slots. Transitions that stay in the same state have no side effect.

Top module: `holdover_freq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: word equal to `NOMINAL_WORD`, status 2'b10 (freerun), wide-track 0. Both snapshot slots are empty.
- R2: With mode input 2'b00 (tracking), the output word one clock later equals the live word sampled at that edge, and the status is 2'b00.
- R3: While in tracking state with lock high, a snapshot of the live word is taken on every `TICKS_PER_SAMPLE`-th tick, alternating between the two slots. The tick count restarts whenever tracking-and-locked is false.
- R4: With mode input 2'b01, the status is 2'b01. On entry to holdover, the output word is the older of the two stored snapshots. The word then stays constant for as long as holdover lasts, whatever the live word does.
- R5: On holdover entry with only one valid snapshot, that snapshot is output. With none valid, `NOMINAL_WORD` is output.
- R6: With mode input 2'b10 or 2'b11, the status is 2'b10 and the output word is `NOMINAL_WORD`.
- R7: No snapshot is taken in holdover, in freerun, or in tracking without lock. A later holdover still outputs the snapshot from before.
- R8: The wide-track output equals the fast-lock input registered, gated by the mode input being tracking. It is 0 in holdover and freerun.
- R9: Going from holdover back to tracking discards both snapshots. Holdover entered again before a new snapshot is taken outputs `NOMINAL_WORD`.
- R10: Outputs are registered. A mode input change appears on the status and word outputs at the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested mode: 00 track, 01 holdover, 10/11 freerun |
| fast_lock_i | input | 1 | Request for fast acquisition while tracking |
| locked_i | input | 1 | Lock indication from the lock detector |
| live_word_i | input | WORD_W | Live frequency word from the loop filter |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| freq_word_o | output | WORD_W | Frequency word to the controlled oscillator |
| mode_o | output | 2 | Registered mode status |
| wide_track_o | output | 1 | Wide-tracking hint to the loop |

## Verification
The snapshot function is driven with a live word that changes every cycle, so each snapshot value is unique and the bench can tell which slot was replayed. The tick is applied every cycle in some runs and every third cycle in others. A long locked run ending in two snapshots shows whether the older or the newer slot is chosen. A short run with exactly one snapshot, and a return from holdover followed by an early re-entry, exercise the single-valid and empty fallbacks. Long stretches of freerun and of unlocked tracking, with ticks running, show whether a snapshot leaks in when it must not. A one-cycle lock drop in the middle of a count shows whether the tick count restarts.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

    typedef enum logic [1:0] {
        ST_TRACK = 2'b00,
        ST_HOLD  = 2'b01,
        ST_FREE  = 2'b10
    } hfm_state_e;

    function automatic hfm_state_e decode_mode(input logic [1:0] code);
        hfm_state_e s;
        unique case (code)
            2'b00:   s = ST_TRACK;
            2'b01:   s = ST_HOLD;
            default: s = ST_FREE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hfm_sample_timer.sv
module hfm_sample_timer #(
    parameter int TICKS_PER_SAMPLE = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic sample_o
);
    localparam int CW = (TICKS_PER_SAMPLE > 1) ? $clog2(TICKS_PER_SAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SAMPLE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sample_o = run_i && tick_i && (cnt_q == LAST);

    // R3: the tick count never passes the sample interval
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a dropped run condition restarts the count
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/hfm_snapshot_store.sv
module hfm_snapshot_store #(
    parameter int          WORD_W       = 24,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] pick_o
);
    localparam int SLOTS = 2;

    logic [WORD_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic              wr_sel_q;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (cap_i && (wr_sel_q == 1'(i))) begin
                slot_q[i] <= word_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            wr_sel_q <= 1'b0;
        end else if (clr_i) begin
            vld_q    <= '0;
            wr_sel_q <= 1'b0;
        end else if (cap_i) begin
            vld_q[wr_sel_q] <= 1'b1;
            wr_sel_q        <= ~wr_sel_q;
        end
    end

    // The slot to be written next holds the older sample.
    always_comb begin
        if (vld_q[wr_sel_q]) begin
            pick_o = slot_q[wr_sel_q];
        end else if (vld_q[~wr_sel_q]) begin
            pick_o = slot_q[~wr_sel_q];
        end else begin
            pick_o = NOMINAL_WORD;
        end
    end

    // R7: without a capture or a clear, the store is frozen
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && !clr_i) |=> ($stable(vld_q) && $stable(wr_sel_q)));

    // R3: successive captures land in alternate slots
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !clr_i) |=> (wr_sel_q != $past(wr_sel_q)));

    // R9: a clear leaves no valid slot
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld_q == '0));

endmodule

// File: rtl/hfm_mode_fsm.sv
module hfm_mode_fsm
    import hfm_pkg::*;
#(
    parameter int          WORD_W       = 24,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              fast_lock_i,
    input  logic              locked_i,
    input  logic [WORD_W-1:0] live_word_i,
    input  logic [WORD_W-1:0] pick_i,
    output logic              run_o,
    output logic              clr_o,
    output logic [WORD_W-1:0] freq_word_o,
    output logic [1:0]        mode_o,
    output logic              wide_o
);
    hfm_state_e state_q, state_d;

    assign state_d = decode_mode(mode_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_word_o <= NOMINAL_WORD;
            mode_o      <= ST_FREE;
            wide_o      <= 1'b0;
        end else begin
            unique case (state_d)
                ST_TRACK: freq_word_o <= live_word_i;
                ST_HOLD:  freq_word_o <= (state_q != ST_HOLD) ? pick_i : freq_word_o;
                default:  freq_word_o <= NOMINAL_WORD;
            endcase
            mode_o <= state_d;
            wide_o <= (state_d == ST_TRACK) && fast_lock_i;
        end
    end

    assign run_o = (state_q == ST_TRACK) && locked_i;
    assign clr_o = (state_q == ST_HOLD) && (state_d == ST_TRACK);

    // R9: a return to tracking from holdover raises the clear
    a_r9_clear_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && mode_i == 2'b00) |-> clr_o);

    // R7: no run condition outside tracking
    a_r7_run_only_tracking: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (mode_o == 2'b00));

endmodule

// File: rtl/holdover_freq_ctrl.sv
module holdover_freq_ctrl #(
    parameter int          WORD_W           = 24,
    parameter int          TICKS_PER_SAMPLE = 30,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              fast_lock_i,
    input  logic              locked_i,
    input  logic [WORD_W-1:0] live_word_i,
    input  logic              tick_ms_i,
    output logic [WORD_W-1:0] freq_word_o,
    output logic [1:0]        mode_o,
    output logic              wide_track_o
);
    logic              run;
    logic              clr;
    logic              sample;
    logic [WORD_W-1:0] pick;

    hfm_sample_timer #(.TICKS_PER_SAMPLE(TICKS_PER_SAMPLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick_ms_i),
        .sample_o (sample)
    );

    hfm_snapshot_store #(.WORD_W(WORD_W), .NOMINAL_WORD(NOMINAL_WORD)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (sample),
        .clr_i  (clr),
        .word_i (live_word_i),
        .pick_o (pick)
    );

    hfm_mode_fsm #(.WORD_W(WORD_W), .NOMINAL_WORD(NOMINAL_WORD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .fast_lock_i (fast_lock_i),
        .locked_i    (locked_i),
        .live_word_i (live_word_i),
        .pick_i      (pick),
        .run_o       (run),
        .clr_o       (clr),
        .freq_word_o (freq_word_o),
        .mode_o      (mode_o),
        .wide_o      (wide_track_o)
    );

    // R2: tracking output is the live word from the previous edge
    a_r2_track_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (freq_word_o == $past(live_word_i)));

    // R6: freerun output is the nominal word
    a_r6_free_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (freq_word_o == NOMINAL_WORD));

    // R4: the word does not move while holdover continues
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && $past(mode_o) == 2'b01) |-> $stable(freq_word_o));

    // R8: wide tracking only while tracking
    a_r8_wide_only_track: assert property (@(posedge clk) disable iff (!rst_n)
        wide_track_o |-> (mode_o == 2'b00));

    // R6: status never shows the unused code
    a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

endmodule

// File: tb/tb_holdover_freq_ctrl.sv
module tb_holdover_freq_ctrl;
    localparam int W = 24;
    localparam int N = 30;
    localparam logic [W-1:0] NOM = 24'h5A5A5A;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b10;
    logic         fast = 1'b0;
    logic         locked = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] live = 24'h000100;
    logic [W-1:0] freq_word;
    logic [1:0]   mode_st;
    logic         wide;

    int errors = 0;
    int checks = 0;
    bit run_chk = 1'b0;
    int tick_every = 1;
    int cyc_n = 0;

    always #10 clk = ~clk;

    holdover_freq_ctrl #(.WORD_W(W), .TICKS_PER_SAMPLE(N), .NOMINAL_WORD(NOM)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .fast_lock_i  (fast),
        .locked_i     (locked),
        .live_word_i  (live),
        .tick_ms_i    (tick),
        .freq_word_o  (freq_word),
        .mode_o       (mode_st),
        .wide_track_o (wide)
    );

    // Behavioural reference model
    int           m_state = 2;
    int           m_cnt = 0;
    logic [W-1:0] m_q[$];
    logic [W-1:0] e_word = NOM;
    int           e_mode = 2;
    bit           e_wide = 1'b0;

    always @(posedge clk) begin
        int nm;
        bit cap;
        if (!rst_n) begin
            m_state = 2; m_cnt = 0; m_q.delete();
            e_word = NOM; e_mode = 2; e_wide = 1'b0;
        end else begin
            nm  = (mode_i == 2'b00) ? 0 : (mode_i == 2'b01) ? 1 : 2;
            cap = 1'b0;
            if (m_state == 0 && locked) begin
                if (tick) begin
                    if (m_cnt == N - 1) begin cap = 1'b1; m_cnt = 0; end
                    else m_cnt++;
                end
            end else begin
                m_cnt = 0;
            end
            if (nm == 0)           e_word = live;
            else if (nm == 2)      e_word = NOM;
            else if (m_state != 1) e_word = (m_q.size() > 0) ? m_q[0] : NOM;
            if (cap) begin
                m_q.push_back(live);
                if (m_q.size() > 2) void'(m_q.pop_front());
            end
            if (m_state == 1 && nm == 0) m_q.delete();
            e_mode = nm; e_wide = (nm == 0) && fast; m_state = nm;
        end
    end

    // Every-cycle comparison
    always @(negedge clk) begin
        if (run_chk) begin
            checks++;
            if (freq_word !== e_word || mode_st !== 2'(e_mode) || wide !== e_wide) begin
                errors++;
                $display("FAIL %s cycle compare: actual word=%h mode=%0d wide=%0b expected word=%h mode=%0d wide=%0b",
                         (e_mode == 0) ? "R2/R3" : (e_mode == 1) ? "R4/R5" : "R6/R7",
                         freq_word, mode_st, wide, e_word, e_mode, e_wide);
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_n++;
            live = live + 24'h000001;
            tick = (tick_every != 0) && (cyc_n % tick_every == 0);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] older, newer, single;
        repeat (3) @(negedge clk);
        chk("R1 word", freq_word, NOM);
        chk("R1 status", W'(mode_st), W'(2'b10));
        chk("R1 wide", W'(wide), '0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        cyc(2);
        chk("R1 empty store", freq_word, NOM);

        // Two snapshots, then holdover picks the older
        mode_i = 2'b00; locked = 1'b1; fast = 1'b1;
        cyc(1);
        chk("R2 follows live", freq_word, live - 24'h1);
        chk("R8 wide in tracking", W'(wide), W'(1));
        cyc(74);
        older = m_q[0]; newer = m_q[1];
        mode_i = 2'b01;
        #1 chk("R10 status before edge", W'(mode_st), W'(2'b00));
        cyc(1);
        chk("R10 status after edge", W'(mode_st), W'(2'b01));
        chk("R4 older snapshot", freq_word, older);
        checks++;
        if (freq_word === newer) begin
            errors++;
            $display("FAIL R4 newest used: actual=%h expected=%h", freq_word, older);
        end
        chk("R8 wide off in holdover", W'(wide), '0);
        cyc(20);
        chk("R4 held constant", freq_word, older);

        // Return clears, early re-entry gives nominal
        mode_i = 2'b00; cyc(10);
        mode_i = 2'b01; cyc(1);
        chk("R9 cleared store", freq_word, NOM);
        cyc(3);

        // Single snapshot fallback
        mode_i = 2'b00; fast = 1'b0; cyc(40);
        single = m_q[0];
        mode_i = 2'b01; cyc(1);
        chk("R5 single valid", freq_word, single);

        // Freerun with code 11, ticks running
        mode_i = 2'b11; cyc(50);
        chk("R6 nominal word", freq_word, NOM);
        chk("R6 status", W'(mode_st), W'(2'b10));
        mode_i = 2'b01; cyc(1);
        chk("R7 no capture in freerun", freq_word, single);
        mode_i = 2'b10; cyc(2);

        // Tracking without lock
        mode_i = 2'b00; locked = 1'b0; cyc(80);
        mode_i = 2'b01; cyc(1);
        chk("R7 no capture unlocked", freq_word, single);

        // Sparse ticks with a lock drop mid-count
        mode_i = 2'b00; locked = 1'b1; fast = 1'b1; tick_every = 3;
        cyc(1);
        chk("R8 wide with fast", W'(wide), W'(1));
        cyc(60);
        locked = 1'b0; cyc(1); locked = 1'b1;
        cyc(150);
        older = (m_q.size() > 0) ? m_q[0] : NOM;
        mode_i = 2'b01; cyc(1);
        chk("R3 sparse-tick snapshot", freq_word, older);
        cyc(5);

        run_chk = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule